// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is one compare channel that sits beside an external 8-bit timer/counter. On every enabled timer tick it compares the counter value with an active compare register. When they are equal it raises a one-cycle compare flag. In clear-on-compare mode it also asks the counter to clear. It keeps a single waveform state bit, and that bit is driven out as the waveform output. The counter, its direction and its TOP/BOTTOM conditions come in from outside, and the CPU reaches the channel through simple write strobes.

Four waveform modes are supported: 00 normal, 01 clear-on-compare, 10 fast PWM and 11 phase-correct PWM. In the two PWM modes, compare writes are held in a buffer until the count reaches TOP, so a pulse is never cut short. A force strobe drives the output as though a match had occurred, with no other effect. A CPU write to the counter hides the match on the tick that follows it.

Top module: `cmp_wave_unit`

## Requirements
- R1: After reset the waveform output, flag and clear request are 0, and the active compare value is 0.
- R2: A match occurs on a cycle with `tick` high, `cnt` equal to the active compare value and no pending block. It makes `flag` high for exactly the next cycle. With `tick` low there is no match.
- R3: In modes 00/01, a match changes the output by `out_mode`: 00 keeps it, 01 toggles it, 10 clears it, 11 sets it.
- R4: `clr_req` pulses together with `flag` only in clear-on-compare mode (01). It is never high in any other mode.
- R5: In modes 00/01, a compare write replaces the active compare value at once. A match in the same cycle still uses the old value.
- R6: In modes 10/11, a compare write goes only to a buffer. The buffer is copied into the active value on a tick with `at_top` high.
- R7: In modes 00/01, `force_stb` applies the `out_mode` action to the output. It sets neither `flag` nor `clr_req`.
- R8: In modes 10/11, `force_stb` is ignored and the output is unchanged.
- R9: A pulse on `wr_cnt` blocks the match on the next tick, however many idle cycles come before that tick. Matches on later ticks occur as normal.
- R10: `out_mode` is not buffered. A new value decides the action of the very next match.
- R11: The waveform output keeps its value when `wave_mode` changes.
- R12: In fast PWM (10), with `out_mode` 10 a match clears the output and a tick at BOTTOM sets it. With `out_mode` 11 both actions are inverted. If a match and BOTTOM fall on the same tick, the match wins.
- R13: In phase-correct PWM (11), with `out_mode` 10 a match clears the output while counting up and sets it while counting down (`cnt_down`=1). With `out_mode` 11 both actions are inverted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_cmp | input | 1 | Write strobe for the compare value |
| wr_cnt | input | 1 | Marks a CPU write to the counter |
| force_stb | input | 1 | Force-compare strobe |
| wdata | input | 8 | Compare write data |
| out_mode | input | 2 | Output action select |
| wave_mode | input | 2 | Waveform mode select |
| tick | input | 1 | Timer clock enable |
| cnt | input | 8 | Counter value |
| cnt_down | input | 1 | Counter is counting down |
| at_top | input | 1 | Counter is at TOP |
| at_bottom | input | 1 | Counter is at BOTTOM |
| flag | output | 1 | Compare match flag pulse |
| clr_req | output | 1 | Counter clear request |
| wave_out | output | 1 | Waveform output state |

## Verification
Every result is registered once, so the flag, the clear request and the output all react at the first clock edge after the stimulus cycle. The bench drives one cycle of inputs, waits for that edge plus 1 ns, and then samples. The block and buffer effects live in hidden state, so they are checked through the flag on a later tick. For the block, the bench counts the intervening idle cycles and then expects no flag on the first tick and a flag on the wrap-around tick after it. For the buffer, it expects no flag for the new value until the tick at TOP has passed.

// File: rtl/cmp_wave_unit.sv
module cmp_wave_unit #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_cmp,
  input  logic         wr_cnt,
  input  logic         force_stb,
  input  logic [W-1:0] wdata,
  input  logic [1:0]   out_mode,
  input  logic [1:0]   wave_mode,
  input  logic         tick,
  input  logic [W-1:0] cnt,
  input  logic         cnt_down,
  input  logic         at_top,
  input  logic         at_bottom,
  output logic         flag,
  output logic         clr_req,
  output logic         wave_out
);
  localparam logic [1:0] WM_CTC  = 2'b01;
  localparam logic [1:0] WM_FAST = 2'b10;

  logic [W-1:0] ocr, ocr_buf;
  logic blk, oc, oc_nx;

  wire pwm = wave_mode[1];
  wire hit = tick && !blk && (cnt == ocr);
  wire frc = force_stb && !pwm;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ocr     <= '0;
      ocr_buf <= '0;
    end else begin
      if (wr_cmp) ocr_buf <= wdata;
      if (wr_cmp && !pwm) ocr <= wdata;
      else if (pwm && tick && at_top) ocr <= ocr_buf;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) blk <= 1'b0;
    else if (wr_cnt) blk <= 1'b1;
    else if (tick) blk <= 1'b0;
  end

  always_comb begin
    oc_nx = oc;
    if (!pwm) begin
      if (hit || frc) begin
        case (out_mode)
          2'b01:   oc_nx = ~oc;
          2'b10:   oc_nx = 1'b0;
          2'b11:   oc_nx = 1'b1;
          default: oc_nx = oc;
        endcase
      end
    end else if (out_mode[1]) begin
      if (hit)
        oc_nx = (wave_mode == WM_FAST) ? out_mode[0] : (out_mode[0] ^ cnt_down);
      else if (wave_mode == WM_FAST && tick && at_bottom)
        oc_nx = ~out_mode[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oc      <= 1'b0;
      flag    <= 1'b0;
      clr_req <= 1'b0;
    end else begin
      oc      <= oc_nx;
      flag    <= hit;
      clr_req <= hit && (wave_mode == WM_CTC);
    end
  end

  assign wave_out = oc;

  AST_FLAG_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    flag |-> $past(tick)); // R2
  AST_CLR_ONLY_CTC: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |-> ($past(wave_mode) == WM_CTC) && flag); // R4
  AST_CNT_WRITE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt ##1 tick |=> !flag); // R9
  AST_FORCE_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (force_stb && !tick) |=> !flag && !clr_req); // R7
  AST_PWM_FORCE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (force_stb && wave_mode[1] && !tick) |=> $stable(wave_out)); // R8
  AST_OUT_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !force_stb) |=> $stable(wave_out)); // R11
endmodule

// File: tb/cmp_wave_unit_test.sv
module cmp_wave_unit_test;
  logic clk = 0, rst_n = 0;
  logic wr_cmp = 0, wr_cnt = 0, force_stb = 0, tick = 0;
  logic cnt_down = 0, at_top = 0, at_bottom = 0;
  logic [7:0] wdata = 0, cnt = 0;
  logic [1:0] out_mode = 0, wave_mode = 0;
  logic flag, clr_req, wave_out;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cmp_wave_unit uut (.clk, .rst_n, .wr_cmp, .wr_cnt, .force_stb, .wdata,
    .out_mode, .wave_mode, .tick, .cnt, .cnt_down, .at_top, .at_bottom,
    .flag, .clr_req, .wave_out);

  // {wm[24:23], om[22:21], wr[20], wd[19:12], cnt[11:4], tick[3], flag[2], clr[1], out[0]}
  localparam logic [24:0] VEC [10] = '{
    {2'b00, 2'b01, 1'b1, 8'h40, 8'h3F, 1'b1, 3'b000}, // R5 old value 0 used
    {2'b00, 2'b01, 1'b0, 8'h00, 8'h40, 1'b1, 3'b101}, // R2 R3 toggle
    {2'b00, 2'b01, 1'b0, 8'h00, 8'h40, 1'b0, 3'b001}, // R2 no tick
    {2'b00, 2'b10, 1'b0, 8'h00, 8'h40, 1'b1, 3'b100}, // R3 R10 clear
    {2'b00, 2'b11, 1'b0, 8'h00, 8'h40, 1'b1, 3'b101}, // R3 R10 set
    {2'b00, 2'b00, 1'b0, 8'h00, 8'h40, 1'b1, 3'b101}, // R3 keep
    {2'b01, 2'b01, 1'b0, 8'h00, 8'h41, 1'b1, 3'b001}, // R2 mismatch
    {2'b01, 2'b01, 1'b0, 8'h00, 8'h40, 1'b1, 3'b110}, // R4 ctc clear req
    {2'b00, 2'b01, 1'b1, 8'h10, 8'h40, 1'b1, 3'b101}, // R5 old value matches
    {2'b00, 2'b01, 1'b0, 8'h00, 8'h10, 1'b1, 3'b100}  // R5 new value active
  };

  task automatic chk(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic chk3(input string tag, input logic ef, input logic ec, input logic eo);
    chk({tag, " flag"}, flag, ef);
    chk({tag, " clr_req"}, clr_req, ec);
    chk({tag, " wave_out"}, wave_out, eo);
  endtask

  task automatic step();
    @(posedge clk); #1;
    wr_cmp = 0; wr_cnt = 0; force_stb = 0; tick = 0; at_top = 0; at_bottom = 0;
  endtask

  task automatic tk(input logic [7:0] c);
    cnt = c; tick = 1; step();
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk3("R1 reset", 0, 0, 0);
    tk(8'h00);
    chk3("R1 reset compare value 0", 1, 0, 0);

    for (int i = 0; i < 10; i++) begin
      wave_mode = VEC[i][24:23]; out_mode = VEC[i][22:21];
      wr_cmp = VEC[i][20]; wdata = VEC[i][19:12];
      cnt = VEC[i][11:4]; tick = VEC[i][3];
      step();
      chk3($sformatf("R2-vector %0d", i), VEC[i][2], VEC[i][1], VEC[i][0]);
    end

    // R7 force in normal and ctc
    wave_mode = 2'b00; out_mode = 2'b01; force_stb = 1; step();
    chk3("R7 force normal", 0, 0, 1);
    wave_mode = 2'b01; force_stb = 1; step();
    chk3("R7 force ctc", 0, 0, 0);

    // R9 block across idle cycles, then wrap-around match
    wave_mode = 2'b00; wr_cnt = 1; step();
    repeat (3) step();
    tk(8'h10);
    chk3("R9 blocked tick", 0, 0, 0);
    tk(8'h11);
    chk3("R9 next count", 0, 0, 0);
    tk(8'h10);
    chk3("R9 wrap match", 1, 0, 1);

    // R8 force ignored in pwm
    wave_mode = 2'b10; out_mode = 2'b10; force_stb = 1; step();
    chk3("R8 pwm force ignored", 0, 0, 1);

    // R6 buffered compare
    out_mode = 2'b00; wr_cmp = 1; wdata = 8'h80; tk(8'h80);
    chk("R6 buffer not yet active", flag, 0);
    tk(8'h10);
    chk("R6 old value still active", flag, 1);
    at_top = 1; tk(8'hFF);
    chk("R6 load at top", flag, 0);
    tk(8'h80);
    chk("R6 new value active", flag, 1);

    // R12 fast pwm
    out_mode = 2'b10; tk(8'h80);
    chk3("R12 non-inv match clears", 1, 0, 0);
    at_bottom = 1; tk(8'h00);
    chk3("R12 non-inv bottom sets", 0, 0, 1);
    out_mode = 2'b11; at_bottom = 1; tk(8'h00);
    chk3("R12 inv bottom clears", 0, 0, 0);
    tk(8'h80);
    chk3("R12 inv match sets", 1, 0, 1);

    // R11 mode change keeps output
    wave_mode = 2'b00; out_mode = 2'b00; step();
    chk("R11 keep on mode change", wave_out, 1);
    wave_mode = 2'b11; step();
    chk("R11 keep on second change", wave_out, 1);

    // R13 phase-correct
    out_mode = 2'b10; cnt_down = 0; tk(8'h80);
    chk3("R13 up match clears", 1, 0, 0);
    cnt_down = 1; tk(8'h80);
    chk3("R13 down match sets", 1, 0, 1);
    out_mode = 2'b11; cnt_down = 1; tk(8'h80);
    chk3("R13 inv down match clears", 1, 0, 0);
    cnt_down = 0; tk(8'h80);
    chk3("R13 inv up match sets", 1, 0, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule